// File: doc/BRIEF.md
# Address Window Decode and Remap

This block checks each incoming bus address against one programmable address window. When the address lands inside the window, the block raises a hit flag in the same cycle. One cycle later it presents a translated local address. The upper bits of that address come from a remap value and the lower bits are the offset inside the window.

Software programs three registers through a plain write/read port.

- **Range register**: holds a mask with ones over the decoded upper bits. Its bit 0 selects an I/O window (1) or a memory window (0).
- **Window base register**: holds the value that the masked address must equal.
- **Remap register**: holds the replacement upper bits. Its bit 0 is the window enable.

A memory window always passes address bits [3:0] through untouched. An I/O window also decodes and remaps bits [3:2].

Addresses arrive on a valid/ready stream and translated addresses leave on another.

- An input is accepted when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in that cycle (`out_ready` high).
- A hit loads the output register.
- A miss is accepted and dropped.
- `out_valid` stays high with a stable `out_addr` until `out_ready` is seen.

Top module: `addr_window_remap`

## Requirements
- R1: After reset all three registers read 0, `hit` is 0 and `out_valid` is 0.
- R2: While remap bit 0 (enable) is 0, `hit` stays 0 and no address is ever produced.
- R3: Reserved bits read 0 whatever was written: bit 1 of the range (offset 0) and remap (offset 1) registers, and bits [1:0] of the base register (offset 2). All other bits read back as written.
- R4: `hit` is `in_valid & enable & ((in_addr & M) == (base & M))` in the same cycle, where M is the effective mask.
- R5: On an accepted hit, `out_valid` rises on the next clock with `out_addr = (in_addr & ~M) | (R & M)`, where R is the effective remap value.
- R6: For a memory window (range bit 0 = 0), M and R have bits [3:0] cleared, so `out_addr[3:0]` equals `in_addr[3:0]`.
- R7: For an I/O window (range bit 0 = 1), M and R have only bits [1:0] cleared, so mask and remap bits [3:2] take part in both decode and translation.
- R8: `in_ready` equals `!out_valid | out_ready`. While `out_valid` is high and `out_ready` is low, `out_addr` and `out_valid` hold.
- R9: An accepted miss is dropped and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 range, 1 remap, 2 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Block can take an input address |
| in_addr | input | 32 | Incoming bus address |
| hit | output | 1 | Current input address falls in the enabled window |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Downstream takes the translated address |
| out_addr | output | 32 | Translated local address |

## Verification
The bench compares the design with its own model on every clock, and goes after four corner cases.

- **Bits [3:2]:** it switches the window between memory and I/O kinds with identical register contents. A design that let bits [3:2] leak into a memory decode would miss addresses that differ only in those bits. A design that dropped them from an I/O remap would return the wrong translated address.
- **Enable cleared:** it leaves the enable bit cleared while sending matching addresses. A design that ignored the enable would report hits.
- **Reserved bits:** it writes all ones and reads back, which shows reserved bits that were stored.
- **Back-pressure:** random stalls on `out_ready` expose a register that is overwritten or dropped while stalled.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RANGE = 2'd0,
    SEL_REMAP = 2'd1,
    SEL_BASE  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/awr_regs.sv
module awr_regs import awr_pkg::*; #(
  parameter int unsigned AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    wdata,
  output logic [AW-1:0]    rdata,
  output logic [AW-1:0]    eff_mask,
  output logic [AW-1:0]    eff_remap,
  output logic [AW-1:0]    base,
  output logic             enable
);
  localparam logic [AW-1:0] CTRL_KEEP = {{(AW-2){1'b1}}, 2'b01};
  localparam logic [AW-1:0] BASE_KEEP = {{(AW-2){1'b1}}, 2'b00};

  logic [AW-1:0] range_q, remap_q, base_q;
  logic          io_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_q <= '0;
      remap_q <= '0;
      base_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_RANGE: range_q <= wdata & CTRL_KEEP;
        SEL_REMAP: remap_q <= wdata & CTRL_KEEP;
        SEL_BASE:  base_q  <= wdata & BASE_KEEP;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_RANGE: rdata = range_q;
      SEL_REMAP: rdata = remap_q;
      SEL_BASE:  rdata = base_q;
      default:   rdata = '0;
    endcase
  end

  assign io_win    = range_q[0];
  assign enable    = remap_q[0];
  assign base      = base_q;
  assign eff_mask  = {range_q[AW-1:4], range_q[3:2] & {2{io_win}}, 2'b00};
  assign eff_remap = {remap_q[AW-1:4], remap_q[3:2] & {2{io_win}}, 2'b00};
endmodule

// File: rtl/awr_match.sv
module awr_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] remap,
  input  logic          enable,
  output logic          in_window,
  output logic [AW-1:0] local_addr
);
  assign in_window  = enable && ((addr & mask) == (base & mask));
  assign local_addr = (addr & ~mask) | (remap & mask);
endmodule

// File: rtl/awr_out_stage.sv
module awr_out_stage #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_hit,
  input  logic [AW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready && in_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_window_remap.sv
module addr_window_remap import awr_pkg::*; #(
  parameter int unsigned AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_addr,
  output logic             hit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_addr
);
  logic [AW-1:0] mask_w, remap_w, base_w, local_w;
  logic          win_en, in_window;

  awr_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .eff_mask(mask_w), .eff_remap(remap_w), .base(base_w),
    .enable(win_en)
  );

  awr_match #(.AW(AW)) u_match (
    .addr(in_addr), .mask(mask_w), .base(base_w), .remap(remap_w),
    .enable(win_en), .in_window(in_window), .local_addr(local_w)
  );

  assign hit = in_valid && in_window;

  awr_out_stage #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hit(in_window),
    .in_data(local_w), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_addr)
  );
endmodule

// File: rtl/awr_checker.sv
module awr_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_en,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] in_addr,
  input logic          hit,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr
);
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !hit); // R2

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R8

  AST_HIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_ready) |=> out_valid); // R5

  AST_MISS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hit && !(out_valid && !out_ready)) |=> !out_valid); // R9

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_ready) |=> (out_addr[1:0] == $past(in_addr[1:0]))); // R6
endmodule

bind addr_window_remap awr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_en(win_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_addr(in_addr), .hit(hit), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr)
);

// File: tb/addr_window_remap_bench.sv
module addr_window_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        hit;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;

  int unsigned n_tests = 0;
  int unsigned n_fail = 0;
  string       cur_req = "R1";
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  addr_window_remap u_addr_window_remap (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .hit(hit), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr)
  );

  // reference model
  logic [31:0] m_range = '0, m_remap = '0, m_base = '0, m_oa = '0;
  logic        m_ov = 1'b0;

  function automatic logic [31:0] f_mask();
    logic [31:0] m = m_range & 32'hFFFF_FFFC;
    if (!m_range[0]) m = m & 32'hFFFF_FFF0;   // memory window: R6
    return m;
  endfunction

  function automatic logic [31:0] f_remap();
    return m_range[0] ? (m_remap & 32'hFFFF_FFFC) : (m_remap & 32'hFFFF_FFF0); // R7
  endfunction

  function automatic bit f_hit(logic [31:0] a);
    logic [31:0] m = f_mask();
    return m_remap[0] && ((a & m) == (m_base & m));
  endfunction

  function automatic logic [31:0] f_local(logic [31:0] a);
    logic [31:0] m = f_mask();
    return (a & ~m) | (f_remap() & m);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_range <= '0; m_remap <= '0; m_base <= '0; m_ov <= 1'b0; m_oa <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr == 2'd0) m_range <= reg_wdata & 32'hFFFF_FFFD;
        if (reg_addr == 2'd1) m_remap <= reg_wdata & 32'hFFFF_FFFD;
        if (reg_addr == 2'd2) m_base  <= reg_wdata & 32'hFFFF_FFFC;
      end
      if (in_valid && (!m_ov || out_ready) && f_hit(in_addr)) begin
        m_ov <= 1'b1;
        m_oa <= f_local(in_addr);
      end else if (out_ready) begin
        m_ov <= 1'b0;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle stream comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "hit", {31'd0, hit}, {31'd0, in_valid && f_hit(in_addr)});
      check("R8", "in_ready", {31'd0, in_ready}, {31'd0, !m_ov || out_ready});
      check(cur_req, "out_valid", {31'd0, out_valid}, {31'd0, m_ov});
      if (m_ov) check(cur_req, "out_addr", out_addr, m_oa);
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    check(req, "readback", reg_rdata, exp);
  endtask

  task automatic send(logic [31:0] a, bit rdy);
    @(posedge clk); #2;
    in_valid = 1'b1; in_addr = a; out_ready = rdy;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1", "hit", {31'd0, hit}, 32'd0);
    check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    rd(2'd0, 32'd0, "R1"); rd(2'd1, 32'd0, "R1"); rd(2'd2, 32'd0, "R1");

    // R3 reserved bits
    cur_req = "R3";
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'hFFFF_FFFE); wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, 32'hFFFF_FFFD, "R3"); rd(2'd1, 32'hFFFF_FFFC, "R3"); rd(2'd2, 32'hFFFF_FFFC, "R3");

    // R2 disabled window: matching address never hits
    cur_req = "R2";
    wr(2'd0, 32'hFFFF_0000); wr(2'd2, 32'h1234_0000); wr(2'd1, 32'hABCD_0004);
    send(32'h1234_5678, 1'b1);
    @(negedge clk);
    check("R2", "hit disabled", {31'd0, hit}, 32'd0);
    idle(); idle();

    // R5 / R6 memory window
    cur_req = "R6";
    wr(2'd0, 32'hFFFF_FFFC); wr(2'd1, 32'hABCD_0005);
    send(32'h1234_0009, 1'b1); idle();
    @(negedge clk);
    check("R6", "mem offset", out_addr, 32'hABCD_0009);
    cur_req = "R5";
    wr(2'd0, 32'hFFFF_0000);
    send(32'h1234_5678, 1'b1); idle();
    @(negedge clk);
    check("R5", "remap", out_addr, 32'hABCD_5678);

    // R7 I/O window
    cur_req = "R7";
    wr(2'd0, 32'hFFFF_FFFD); wr(2'd2, 32'h1234_0008);
    send(32'h1234_0006, 1'b1);
    @(negedge clk);
    check("R7", "io miss", {31'd0, hit}, 32'd0);
    send(32'h1234_000B, 1'b1); idle();
    @(negedge clk);
    check("R7", "io remap", out_addr, 32'hABCD_0007);

    // R9 misses and R8 stall, then random traffic
    cur_req = "R9";
    send(32'h5555_0000, 1'b1); send(32'h0000_0010, 1'b1); idle();
    cur_req = "R8";
    send(32'h1234_0008, 1'b0); send(32'h1234_0009, 1'b0); send(32'h1234_000A, 1'b0);
    send(32'h1234_000B, 1'b1); idle();

    cur_req = "R4";
    for (int cfg = 0; cfg < 12; cfg++) begin
      int unsigned k = 2 + ($urandom % 14);
      logic [31:0] msk = 32'hFFFF_FFFF << k;
      logic [31:0] bs = $urandom;
      logic [31:0] rm = $urandom;
      idle();
      wr(2'd0, msk | {31'd0, 1'($urandom % 2)});
      wr(2'd2, bs);
      wr(2'd1, rm | {31'd0, 1'(($urandom % 8) != 0)});
      for (int i = 0; i < 120; i++) begin
        logic [31:0] a = ($urandom % 2) ? ((bs & msk) | ($urandom & ~msk)) : $urandom;
        @(posedge clk); #2;
        in_valid  = ($urandom % 4) != 0;
        in_addr   = a;
        out_ready = ($urandom % 3) != 0;
      end
    end
    idle(); idle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule